// File: doc/BRIEF.md
# Round-Robin Shared-Bus Wishbone Interconnect

This block joins several Wishbone master ports to several Wishbone slave ports over one shared bus. Masters that raise `cyc` compete for that bus, and a rotating-priority arbiter picks one of them. The grant is registered and stays with the owner for as long as it keeps `cyc` high. The owner's word address is compared against a base/size window for each slave. The bus cycle is steered to the matching slave only. That slave's read data and termination signals return to the owner only.

Address and data widths are parameters. Each address value selects one full data word. The select vector is as wide as the data width divided by a granularity parameter, which may be 8, 16, 32 or 64. Error, retry, stall, lock, cycle-type and burst-type signals can each be switched on by their own parameter. An address that hits no window is terminated inside the block, so the owner never waits forever. The whole block runs on one clock with one reset. No width conversion is done.

Top module: `wb_rr_interconnect`

## Requirements
- R1: While reset is asserted, no slave sees `cyc` or `stb` and no master sees ack, err or rty. The first grant after reset goes to master 0 when it requests.
- R2: While a master holds the grant, its `cyc` and `stb` reach only the slave j for which base_j <= address < base_j + size_j. Its address, write enable, write data and select lines appear unchanged on the shared slave outputs.
- R3: If windows overlap, the lowest-indexed matching slave receives the cycle. With the default windows, an address in 0x0000-0x1FFF or 0x4000-0x47FF goes to slave 0, 1 or 2 rather than to slave 3, whose window 0x0000-0x7FFF is the widest.
- R4: A grant is registered at the clock edge after a request is sampled. When the owner drops `cyc`, the next grant goes at the following edge to the nearest requesting master above the previous owner in index order, wrapping from the highest index back to 0.
- R5: While the owner keeps `cyc` high, the grant does not move, whatever the other masters request.
- R6: The owner receives the selected slave's read data, ack, err and rty in the same cycle. Every master that does not hold the grant sees ack, err and rty low and read data zero.
- R7: With stall enabled, the owner sees the selected slave's stall, and every master that does not hold the grant sees stall high.
- R8: If the owner strobes an address that no window holds, no slave is selected. One clock edge later the owner gets a one-cycle err (ack if err is disabled) with read data zero, and ack stays low.
- R9: With lock, cycle-type and burst-type enabled, the owner's lock, 3-bit cycle type and 2-bit burst type are carried unchanged to the shared slave outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_cyc_i | input | N_MST | Bus-cycle request, one bit per master |
| m_stb_i | input | N_MST | Strobe, one bit per master |
| m_we_i | input | N_MST | Write enable, one bit per master |
| m_adr_i | input | N_MST*AW | Word addresses, master i in bits [i*AW +: AW] |
| m_dat_i | input | N_MST*DW | Write data per master |
| m_sel_i | input | N_MST*DW/GRAN | Select lines per master |
| m_lock_i | input | N_MST | Lock request per master |
| m_cti_i | input | N_MST*3 | Cycle type per master |
| m_bte_i | input | N_MST*2 | Burst type per master |
| m_dat_o | output | N_MST*DW | Read data per master |
| m_ack_o | output | N_MST | Normal termination per master |
| m_err_o | output | N_MST | Error termination per master |
| m_rty_o | output | N_MST | Retry termination per master |
| m_stall_o | output | N_MST | Stall per master |
| s_cyc_o | output | N_SLV | Bus cycle, one bit per slave |
| s_stb_o | output | N_SLV | Strobe, one bit per slave |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | AW | Shared word address |
| s_dat_o | output | DW | Shared write data |
| s_sel_o | output | DW/GRAN | Shared select lines |
| s_lock_o | output | 1 | Shared lock |
| s_cti_o | output | 3 | Shared cycle type |
| s_bte_o | output | 2 | Shared burst type |
| s_dat_i | input | N_SLV*DW | Read data per slave |
| s_ack_i | input | N_SLV | Ack per slave |
| s_err_i | input | N_SLV | Err per slave |
| s_rty_i | input | N_SLV | Rty per slave |
| s_stall_i | input | N_SLV | Stall per slave |

## Verification
Only the grant is registered. A request sampled at one rising edge gives ownership from that edge on, and a release moves the grant at the edge after `cyc` is seen low. Routing, forwarded fields and returned terminations are combinational inside the owned cycle, while the no-window err arrives one further edge later. The bench changes inputs just after a falling edge and samples outputs at the next falling edge, so each check falls in the half cycle where its value is due: the first falling edge after the granting edge for routing, and the next one for the fallback err.

// File: rtl/wb_rr_pkg.sv
package wb_rr_pkg;

  // index width for a count of n items, at least one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bit legal_gran(input int unsigned g);
    return (g == 8) || (g == 16) || (g == 32) || (g == 64);
  endfunction

  localparam int unsigned CTI_W = 3;
  localparam int unsigned BTE_W = 2;

endpackage

// File: rtl/wb_rr_arbiter.sv
module wb_rr_arbiter
  import wb_rr_pkg::*;
#(
  parameter int unsigned N_REQ = 3,
  localparam int unsigned IW = idx_bits(N_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic             gnt_vld,
  output logic [IW-1:0]    gnt_idx,
  output logic [N_REQ-1:0] gnt_oh
);

  logic          vld_q, vld_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          hold;
  logic          upd_en;

  // owner keeps the bus while its cyc stays high
  assign hold   = vld_q && req[idx_q];
  assign upd_en = !hold;

  // rotating search starting just above the last owner
  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    if (upd_en) begin
      vld_d = 1'b0;
      for (int k = 1; k <= int'(N_REQ); k++) begin
        if (!vld_d && req[(int'(idx_q) + k) % int'(N_REQ)]) begin
          vld_d = 1'b1;
          idx_d = IW'((int'(idx_q) + k) % int'(N_REQ));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= IW'(N_REQ - 1);
    end else if (upd_en) begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  assign gnt_vld = vld_q;
  assign gnt_idx = idx_q;

  for (genvar i = 0; i < int'(N_REQ); i++) begin : g_oh
    assign gnt_oh[i] = vld_q && (idx_q == IW'(i));
  end

endmodule

// File: rtl/wb_rr_decoder.sv
module wb_rr_decoder
  import wb_rr_pkg::*;
#(
  parameter int unsigned            N_TGT = 4,
  parameter int unsigned            AW    = 16,
  parameter logic [N_TGT*AW-1:0]    BASE  = '0,
  parameter logic [N_TGT*AW-1:0]    SIZE  = '1,
  localparam int unsigned           IW    = idx_bits(N_TGT)
) (
  input  logic [AW-1:0]    adr,
  output logic [N_TGT-1:0] hit_oh,
  output logic [IW-1:0]    hit_idx,
  output logic             miss
);

  logic [N_TGT-1:0] raw_hit;

  // half-open window test: offset from base, no borrow, below size
  for (genvar j = 0; j < int'(N_TGT); j++) begin : g_win
    localparam logic [AW:0] LO = {1'b0, BASE[j*AW +: AW]};
    logic [AW:0] diff;
    assign diff       = {1'b0, adr} - LO;
    assign raw_hit[j] = !diff[AW] && (diff[AW-1:0] < SIZE[j*AW +: AW]);
  end

  // lowest index wins on overlap
  always_comb begin
    hit_oh  = '0;
    hit_idx = '0;
    for (int j = 0; j < int'(N_TGT); j++) begin
      if (raw_hit[j] && (hit_oh == '0)) begin
        hit_oh[j] = 1'b1;
        hit_idx   = IW'(j);
      end
    end
  end

  assign miss = ~|raw_hit;

endmodule

// File: rtl/wb_rr_fallback.sv
module wb_rr_fallback (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic pulse
);

  logic pulse_q, pulse_d;

  // one-cycle termination per strobed beat to an empty address
  always_comb pulse_d = want && !pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/wb_rr_interconnect.sv
module wb_rr_interconnect
  import wb_rr_pkg::*;
#(
  parameter int unsigned          N_MST     = 3,
  parameter int unsigned          N_SLV     = 4,
  parameter int unsigned          AW        = 16,
  parameter int unsigned          DW        = 32,
  parameter int unsigned          GRAN      = 8,
  parameter logic [N_SLV*AW-1:0]  SLV_BASE  = {16'h0000, 16'h4000, 16'h1000, 16'h0000},
  parameter logic [N_SLV*AW-1:0]  SLV_SIZE  = {16'h8000, 16'h0800, 16'h1000, 16'h1000},
  parameter bit                   USE_ERR   = 1'b1,
  parameter bit                   USE_RTY   = 1'b1,
  parameter bit                   USE_STALL = 1'b1,
  parameter bit                   USE_LOCK  = 1'b1,
  parameter bit                   USE_CTI   = 1'b1,
  parameter bit                   USE_BTE   = 1'b1,
  localparam int unsigned         SW        = DW / GRAN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        m_cyc_i,
  input  logic [N_MST-1:0]        m_stb_i,
  input  logic [N_MST-1:0]        m_we_i,
  input  logic [N_MST*AW-1:0]     m_adr_i,
  input  logic [N_MST*DW-1:0]     m_dat_i,
  input  logic [N_MST*SW-1:0]     m_sel_i,
  input  logic [N_MST-1:0]        m_lock_i,
  input  logic [N_MST*CTI_W-1:0]  m_cti_i,
  input  logic [N_MST*BTE_W-1:0]  m_bte_i,
  output logic [N_MST*DW-1:0]     m_dat_o,
  output logic [N_MST-1:0]        m_ack_o,
  output logic [N_MST-1:0]        m_err_o,
  output logic [N_MST-1:0]        m_rty_o,
  output logic [N_MST-1:0]        m_stall_o,
  output logic [N_SLV-1:0]        s_cyc_o,
  output logic [N_SLV-1:0]        s_stb_o,
  output logic                    s_we_o,
  output logic [AW-1:0]           s_adr_o,
  output logic [DW-1:0]           s_dat_o,
  output logic [SW-1:0]           s_sel_o,
  output logic                    s_lock_o,
  output logic [CTI_W-1:0]        s_cti_o,
  output logic [BTE_W-1:0]        s_bte_o,
  input  logic [N_SLV*DW-1:0]     s_dat_i,
  input  logic [N_SLV-1:0]        s_ack_i,
  input  logic [N_SLV-1:0]        s_err_i,
  input  logic [N_SLV-1:0]        s_rty_i,
  input  logic [N_SLV-1:0]        s_stall_i
);

  localparam int unsigned MIW = idx_bits(N_MST);
  localparam int unsigned SIW = idx_bits(N_SLV);

  if (!legal_gran(GRAN) || (DW % GRAN) != 0) begin : g_bad_gran
    $error("granularity must be 8, 16, 32 or 64 and divide the data width");
  end

  // ---------------- per-master views ----------------
  logic [AW-1:0]    mv_adr [N_MST];
  logic [DW-1:0]    mv_dat [N_MST];
  logic [SW-1:0]    mv_sel [N_MST];
  logic [CTI_W-1:0] mv_cti [N_MST];
  logic [BTE_W-1:0] mv_bte [N_MST];
  logic [DW-1:0]    sv_dat [N_SLV];

  for (genvar i = 0; i < int'(N_MST); i++) begin : g_mv
    assign mv_adr[i] = m_adr_i[i*AW +: AW];
    assign mv_dat[i] = m_dat_i[i*DW +: DW];
    assign mv_sel[i] = m_sel_i[i*SW +: SW];
    assign mv_cti[i] = m_cti_i[i*CTI_W +: CTI_W];
    assign mv_bte[i] = m_bte_i[i*BTE_W +: BTE_W];
  end

  for (genvar j = 0; j < int'(N_SLV); j++) begin : g_sv
    assign sv_dat[j] = s_dat_i[j*DW +: DW];
  end

  // ---------------- arbitration ----------------
  logic             gnt_vld;
  logic [MIW-1:0]   gnt_idx;
  logic [N_MST-1:0] gnt_oh;

  wb_rr_arbiter #(.N_REQ(N_MST)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (m_cyc_i),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .gnt_oh  (gnt_oh)
  );

  logic          own_cyc, own_stb;
  logic [AW-1:0] own_adr;

  assign own_cyc = gnt_vld && m_cyc_i[gnt_idx];
  assign own_stb = own_cyc && m_stb_i[gnt_idx];
  assign own_adr = mv_adr[gnt_idx];

  // ---------------- address decode ----------------
  logic [N_SLV-1:0] dec_oh;
  logic [SIW-1:0]   dec_idx;
  logic             dec_miss;

  wb_rr_decoder #(
    .N_TGT (N_SLV),
    .AW    (AW),
    .BASE  (SLV_BASE),
    .SIZE  (SLV_SIZE)
  ) u_dec (
    .adr     (own_adr),
    .hit_oh  (dec_oh),
    .hit_idx (dec_idx),
    .miss    (dec_miss)
  );

  // ---------------- request path ----------------
  assign s_cyc_o  = own_cyc ? dec_oh : '0;
  assign s_stb_o  = own_stb ? dec_oh : '0;
  assign s_we_o   = gnt_vld && m_we_i[gnt_idx];
  assign s_adr_o  = own_adr;
  assign s_dat_o  = mv_dat[gnt_idx];
  assign s_sel_o  = mv_sel[gnt_idx];

  if (USE_LOCK) begin : g_lock
    assign s_lock_o = gnt_vld && m_lock_i[gnt_idx];
  end else begin : g_nolock
    assign s_lock_o = 1'b0;
  end

  if (USE_CTI) begin : g_cti
    assign s_cti_o = mv_cti[gnt_idx];
  end else begin : g_nocti
    assign s_cti_o = '0;
  end

  if (USE_BTE) begin : g_bte
    assign s_bte_o = mv_bte[gnt_idx];
  end else begin : g_nobte
    assign s_bte_o = '0;
  end

  // ---------------- fallback terminator ----------------
  logic fb_want, fb_pulse;

  assign fb_want = own_stb && dec_miss;

  wb_rr_fallback u_fb (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (fb_want),
    .pulse (fb_pulse)
  );

  // ---------------- response path ----------------
  logic          sl_ack, sl_err, sl_rty, sl_stall;
  logic          rt_ack, rt_err, rt_rty;
  logic [DW-1:0] rt_dat;

  assign sl_ack   = |(s_ack_i & dec_oh);
  assign sl_err   = USE_ERR   && |(s_err_i & dec_oh);
  assign sl_rty   = USE_RTY   && |(s_rty_i & dec_oh);
  assign sl_stall = USE_STALL && |(s_stall_i & dec_oh);

  assign rt_ack = sl_ack || (fb_pulse && !USE_ERR);
  assign rt_err = sl_err || (fb_pulse && USE_ERR);
  assign rt_rty = sl_rty;
  assign rt_dat = dec_miss ? '0 : sv_dat[dec_idx];

  for (genvar i = 0; i < int'(N_MST); i++) begin : g_ret
    assign m_ack_o[i]          = gnt_oh[i] && rt_ack;
    assign m_err_o[i]          = gnt_oh[i] && rt_err;
    assign m_rty_o[i]          = gnt_oh[i] && rt_rty;
    assign m_dat_o[i*DW +: DW] = gnt_oh[i] ? rt_dat : '0;
    if (USE_STALL) begin : g_st
      assign m_stall_o[i] = gnt_oh[i] ? sl_stall : 1'b1;
    end else begin : g_nost
      assign m_stall_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/wb_rr_interconnect_checker.sv
module wb_rr_interconnect_checker
  import wb_rr_pkg::*;
#(
  parameter int unsigned N_MST     = 3,
  parameter int unsigned N_SLV     = 4,
  parameter bit          USE_STALL = 1'b1,
  localparam int unsigned MIW      = idx_bits(N_MST)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] m_cyc_i,
  input logic [N_MST-1:0] m_ack_o,
  input logic [N_MST-1:0] m_err_o,
  input logic [N_MST-1:0] m_rty_o,
  input logic [N_MST-1:0] m_stall_o,
  input logic [N_SLV-1:0] s_cyc_o,
  input logic             gnt_vld,
  input logic [MIW-1:0]   gnt_idx
);

  logic owner_busy;
  assign owner_busy = gnt_vld && m_cyc_i[gnt_idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert ((s_cyc_o == '0) && (m_ack_o == '0)); // R1
    end
  end

  AST_ONE_SLAVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_cyc_o)); // R2

  AST_SLAVE_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_cyc_o) |-> owner_busy); // R2

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    owner_busy |=> (gnt_vld && $stable(gnt_idx))); // R5

  AST_ONE_MASTER_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ack_o | m_err_o | m_rty_o)); // R6

  if (USE_STALL) begin : g_stall_chk
    AST_OTHERS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(m_stall_o) >= int'(N_MST) - 1)); // R7
  end

endmodule

bind wb_rr_interconnect wb_rr_interconnect_checker #(
  .N_MST     (N_MST),
  .N_SLV     (N_SLV),
  .USE_STALL (USE_STALL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_cyc_i   (m_cyc_i),
  .m_ack_o   (m_ack_o),
  .m_err_o   (m_err_o),
  .m_rty_o   (m_rty_o),
  .m_stall_o (m_stall_o),
  .s_cyc_o   (s_cyc_o),
  .gnt_vld   (gnt_vld),
  .gnt_idx   (gnt_idx)
);

// File: tb/wb_rr_interconnect_bench.sv
module wb_rr_interconnect_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NM = 3;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam logic [NS*AW-1:0] BASES = {16'h0000, 16'h4000, 16'h1000, 16'h0000};
  localparam logic [NS*AW-1:0] SIZES = {16'h8000, 16'h0800, 16'h1000, 16'h1000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [NM-1:0]    m_cyc = '0, m_stb = '0, m_we = '0, m_lock = '0;
  logic [NM*AW-1:0] m_adr = '0;
  logic [NM*DW-1:0] m_wd = '0;
  logic [NM*SW-1:0] m_sel = '0;
  logic [NM*3-1:0]  m_cti = '0;
  logic [NM*2-1:0]  m_bte = '0;
  logic [NM*DW-1:0] m_rd;
  logic [NM-1:0]    m_ack, m_err, m_rty, m_stall;
  logic [NS-1:0]    s_cyc, s_stb;
  logic             s_we, s_lock;
  logic [AW-1:0]    s_adr;
  logic [DW-1:0]    s_wd;
  logic [SW-1:0]    s_sel;
  logic [2:0]       s_cti;
  logic [1:0]       s_bte;
  logic [NS*DW-1:0] s_rd;
  logic [NS-1:0]    s_ack, s_err, s_rty, s_stall;
  logic [NS-1:0]    slv_err = '0, slv_rty = '0, slv_stall = '0;

  wb_rr_interconnect u_wb_rr_interconnect (
    .clk(clk), .rst_n(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
    .m_dat_i(m_wd), .m_sel_i(m_sel), .m_lock_i(m_lock), .m_cti_i(m_cti),
    .m_bte_i(m_bte), .m_dat_o(m_rd), .m_ack_o(m_ack), .m_err_o(m_err),
    .m_rty_o(m_rty), .m_stall_o(m_stall),
    .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we), .s_adr_o(s_adr),
    .s_dat_o(s_wd), .s_sel_o(s_sel), .s_lock_o(s_lock), .s_cti_o(s_cti),
    .s_bte_o(s_bte), .s_dat_i(s_rd), .s_ack_i(s_ack), .s_err_i(s_err),
    .s_rty_i(s_rty), .s_stall_i(s_stall)
  );

  function automatic logic [DW-1:0] slave_word(input int j, input logic [AW-1:0] a);
    return (DW'(j + 1) << 28) ^ {16'h0A5A, a};
  endfunction

  // bench slave models: answer in the strobed cycle
  always_comb begin
    for (int j = 0; j < NS; j++) begin
      s_rd[j*DW +: DW] = slave_word(j, s_adr);
      s_stall[j] = slv_stall[j];
      s_err[j]   = s_cyc[j] && s_stb[j] && slv_err[j];
      s_rty[j]   = s_cyc[j] && s_stb[j] && slv_rty[j];
      s_ack[j]   = s_cyc[j] && s_stb[j] && !slv_err[j] && !slv_rty[j] && !slv_stall[j];
    end
  end

  function automatic int exp_slave(input logic [AW-1:0] a);
    for (int j = 0; j < NS; j++) begin
      if ((17'(a) >= 17'(BASES[j*AW +: AW])) &&
          (17'(a) <  17'(BASES[j*AW +: AW]) + 17'(SIZES[j*AW +: AW])))
        return j;
    end
    return -1;
  endfunction

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int i, input bit cyc, input logic [AW-1:0] a, input bit we,
                       input logic [DW-1:0] d, input logic [SW-1:0] sel,
                       input bit lock, input logic [2:0] cti, input logic [1:0] bte);
    m_cyc[i] = cyc; m_stb[i] = cyc; m_we[i] = we; m_lock[i] = lock;
    m_adr[i*AW +: AW] = a; m_wd[i*DW +: DW] = d; m_sel[i*SW +: SW] = sel;
    m_cti[i*3 +: 3] = cti; m_bte[i*2 +: 2] = bte;
  endtask

  // one full transfer from an idle bus; entered just after a falling edge
  task automatic xfer(input int i, input logic [AW-1:0] a, input bit we,
                      input logic [DW-1:0] d, input logic [SW-1:0] sel,
                      input bit lock, input logic [2:0] cti, input logic [1:0] bte);
    int e;
    logic [NM-1:0] me;
    e  = exp_slave(a);
    me = NM'(1) << i;
    drive(i, 1'b1, a, we, d, sel, lock, cti, bte);
    @(negedge clk);
    if (e >= 0) begin
      chk(s_cyc == (NS'(1) << e) && s_stb == (NS'(1) << e), "R2/R3 slave select", 64'(s_cyc), 64'(NS'(1) << e));
      chk(s_adr == a && s_we == we && s_wd == d && s_sel == sel, "R2 forwarded fields",
          {s_adr, s_wd}, {a, d});
      chk(s_lock == lock && s_cti == cti && s_bte == bte, "R9 lock/cti/bte",
          64'({s_lock, s_cti, s_bte}), 64'({lock, cti, bte}));
      chk(m_ack == me && m_err == '0 && m_rty == '0, "R6 ack to owner only", 64'(m_ack), 64'(me));
      chk(m_rd[i*DW +: DW] == slave_word(e, a), "R6 read data", 64'(m_rd[i*DW +: DW]), 64'(slave_word(e, a)));
    end else begin
      chk(s_cyc == '0 && m_err == '0 && m_ack == '0, "R8 no slave, no early term", 64'(s_cyc), 64'h0);
      @(negedge clk);
      chk(m_err == me && m_ack == '0, "R8 fallback err", 64'({m_err, m_ack}), 64'({me, NM'(0)}));
      chk(m_rd == '0, "R8 fallback data zero", 64'(m_rd), 64'h0);
    end
    drive(i, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] pick_adr(input int r);
    case (r)
      0: return AW'(16'h0000 + ($urandom % 16'h1000));
      1: return AW'(16'h1000 + ($urandom % 16'h1000));
      2: return AW'(16'h4000 + ($urandom % 16'h0800));
      3: return AW'(16'h2000 + ($urandom % 16'h2000));
      default: return AW'(16'h8000 + ($urandom % 16'h8000));
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset quiet even with requests present
    m_cyc = '1; m_stb = '1;
    repeat (3) @(negedge clk);
    chk(s_cyc == '0 && s_stb == '0, "R1 slaves idle in reset", 64'(s_cyc), 64'h0);
    chk(m_ack == '0 && m_err == '0 && m_rty == '0, "R1 no term in reset", 64'(m_ack), 64'h0);
    m_cyc = '0; m_stb = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // R3 directed overlap cases
    xfer(1, 16'h0100, 1'b0, 32'h0, 4'hF, 1'b0, 3'd0, 2'd0);
    xfer(0, 16'h2000, 1'b1, 32'hDEAD_BEEF, 4'h3, 1'b1, 3'd2, 2'd1);
    xfer(2, 16'h47FF, 1'b0, 32'h0, 4'h1, 1'b0, 3'd7, 2'd3);
    xfer(2, 16'h4800, 1'b0, 32'h0, 4'h1, 1'b0, 3'd0, 2'd0);
    xfer(0, 16'h8000, 1'b0, 32'h0, 4'h1, 1'b0, 3'd0, 2'd0);  // R8 edge
    xfer(1, 16'hFFFF, 1'b1, 32'h1, 4'h8, 1'b0, 3'd0, 2'd0);  // R8 edge

    // R6: slave err and rty reach the owner
    slv_err[1] = 1'b1;
    drive(2, 1'b1, 16'h1010, 1'b0, '0, 4'hF, 1'b0, '0, '0);
    @(negedge clk);
    chk(m_err == 3'b100 && m_ack == '0, "R6 slave err forwarded", 64'(m_err), 64'h4);
    slv_err[1] = 1'b0; slv_rty[1] = 1'b1;
    @(negedge clk);
    chk(m_rty == 3'b100 && m_ack == '0, "R6 slave rty forwarded", 64'(m_rty), 64'h4);
    slv_rty[1] = 1'b0;
    drive(2, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);

    // R4/R5/R7: contention and rotation
    drive(0, 1'b1, 16'h0010, 1'b0, '0, 4'hF, 1'b0, '0, '0);
    drive(1, 1'b1, 16'h0020, 1'b0, '0, 4'hF, 1'b0, '0, '0);
    drive(2, 1'b1, 16'h0030, 1'b0, '0, 4'hF, 1'b0, '0, '0);
    chk(m_ack == '0 && s_cyc == '0, "R4 no grant before edge", 64'(m_ack), 64'h0);
    @(negedge clk);
    chk(m_ack == 3'b001, "R4 first grant master 0", 64'(m_ack), 64'h1);
    chk(m_stall == 3'b110, "R7 losers stalled", 64'(m_stall), 64'h6);
    @(negedge clk);
    chk(m_ack == 3'b001, "R5 grant held", 64'(m_ack), 64'h1);
    slv_stall[0] = 1'b1;
    #1;
    chk(m_stall == 3'b111 && m_ack == '0, "R7 slave stall to owner", 64'({m_stall, m_ack}), 64'h38);
    slv_stall[0] = 1'b0;
    drive(0, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
    chk(m_ack == 3'b010, "R4 rotate to master 1", 64'(m_ack), 64'h2);
    drive(0, 1'b1, 16'h0010, 1'b0, '0, 4'hF, 1'b0, '0, '0);
    @(negedge clk);
    chk(m_ack == 3'b010, "R5 held against master 0", 64'(m_ack), 64'h2);
    drive(1, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
    chk(m_ack == 3'b100, "R4 rotate to master 2", 64'(m_ack), 64'h4);
    drive(2, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
    chk(m_ack == 3'b001, "R4 wrap to master 0", 64'(m_ack), 64'h1);
    drive(0, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0, '0);
    @(negedge clk);
    chk(s_cyc == '0 && m_ack == '0, "R4 bus idle after release", 64'(s_cyc), 64'h0);

    // constrained random single transfers (R2, R3, R6, R8, R9)
    for (int n = 0; n < 80; n++) begin
      xfer(int'($urandom % NM), pick_adr(int'($urandom % 5)), 1'($urandom),
           DW'($urandom), SW'($urandom), 1'($urandom), 3'($urandom), 2'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule